// File: doc/BRIEF.md
# PWM Prescaler Clock Generator

This block turns one master clock into a family of timebases for a group of PWM channels. A free-running binary counter produces eleven power-of-two ticks, from the master rate down to one tick every 1024 cycles. Two linear dividers, A and B, each take one of those ticks and divide it again by a programmable integer from 1 to 255. Together these give thirteen timebases. Each channel picks one of them on its own.

Every timebase is delivered as an enable strobe that is high for exactly one master-clock cycle. The strobes are not derived clocks, so all downstream logic stays in the single master clock domain. The channel waveform counters that consume these strobes sit outside this block.

Top module: `pwm_clkgen`

## Requirements
- R1: While running, tap k (k = 0..10) on `tap_stb[k]` pulses once every 2^k master cycles. Whenever tap k pulses, every lower tap also pulses in that cycle.
- R2: Divider A pulses `clka_stb` once every (2^p x f) master cycles, where p = `div_a_presel` (0..10) and f = `div_a_factor` (1..255). Each pulse falls in a cycle where tap p pulses. Divider B does the same on `clkb_stb` with its own fields.
- R3: Dividers A and B keep their own periods when they are configured differently at the same time.
- R4: A divide factor of 0 holds that divider's strobe low.
- R5: A prescaler-select code of 11 to 15 holds that divider's strobe low.
- R6: While `rst` is high or `enable` is low, all strobe outputs stay low.
- R7: When `enable` rises, the binary counter restarts from zero, so tap 3 first pulses in the 7th cycle after the cycle in which `enable` went high.
- R8: A change to a divider's select or factor suppresses that divider's strobe in the cycle of the change and restarts its count. With tap 0 and a new factor f, the next strobe arrives exactly f cycles after the changed cycle.
- R9: Channel c reads its 4-bit code from `chan_sel[4c+3:4c]`. Codes 0..10 route tap 0..10, code 11 routes divider A and code 12 routes divider B to `chan_stb[c]`.
- R10: Channel codes 13 to 15 hold that channel's strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global run enable |
| div_a_presel | input | 4 | Tap code that feeds divider A |
| div_a_factor | input | 8 | Divide factor of divider A (0 = off) |
| div_b_presel | input | 4 | Tap code that feeds divider B |
| div_b_factor | input | 8 | Divide factor of divider B (0 = off) |
| chan_sel | input | 16 | Four 4-bit timebase codes, channel 0 in the low nibble |
| tap_stb | output | 11 | Power-of-two tap strobes |
| clka_stb | output | 1 | Divider A strobe |
| clkb_stb | output | 1 | Divider B strobe |
| chan_stb | output | 4 | Selected strobe per channel |

## Verification
A divider's terminal count and a configuration write can land in the same cycle. The bench provokes this by watching divider A pulse with factor 4 and then writing a new factor just after the clock edge that opens the cycle of the next expected pulse. The write must win: no strobe may appear in that cycle, and the next pulse must arrive exactly the new factor's number of cycles later. That spacing shows the count restarted from zero instead of merging the old and new periods.

// File: rtl/pwmclk_pkg.sv
package pwmclk_pkg;

    localparam int NUM_TAPS = 11;
    localparam int NUM_SRC  = NUM_TAPS + 2;
    localparam int SEL_W    = 4;
    localparam int DIV_W    = 8;
    localparam int CNT_W    = NUM_TAPS - 1;
    localparam int SRC_A    = NUM_TAPS;
    localparam int SRC_B    = NUM_TAPS + 1;

    typedef logic [NUM_TAPS-1:0] tap_vec_t;
    typedef logic [NUM_SRC-1:0]  src_vec_t;

    typedef struct packed {
        logic [SEL_W-1:0] presel;
        logic [DIV_W-1:0] factor;
    } div_cfg_t;

    // Picks one tap by code; codes beyond the last tap give 0.
    function automatic logic tap_pick(input tap_vec_t taps, input logic [SEL_W-1:0] code);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_TAPS; i++) begin
            if (code == SEL_W'(i)) r = taps[i];
        end
        return r;
    endfunction

    // Picks one timebase by code; codes beyond the last source give 0.
    function automatic logic src_pick(input src_vec_t srcs, input logic [SEL_W-1:0] code);
        logic r;
        r = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (code == SEL_W'(i)) r = srcs[i];
        end
        return r;
    endfunction

endpackage

// File: rtl/pwmclk_prescaler.sv
module pwmclk_prescaler
    import pwmclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_i,
    output tap_vec_t taps_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    assign taps_o[0] = run_i;

    genvar k;
    generate
        for (k = 1; k < NUM_TAPS; k++) begin : g_tap
            assign taps_o[k] = run_i && (&cnt_q[k-1:0]);
        end
    endgenerate

endmodule

// File: rtl/pwmclk_lindiv.sv
module pwmclk_lindiv
    import pwmclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     run_i,
    input  tap_vec_t taps_i,
    input  div_cfg_t cfg_i,
    output logic     stb_o
);

    div_cfg_t         cfg_q;
    logic [DIV_W-1:0] cnt_q;
    logic             cfg_changed;
    logic             tick;
    logic             active;
    logic             terminal;

    always_comb begin
        cfg_changed = (cfg_i != cfg_q);
        tick        = tap_pick(taps_i, cfg_i.presel);
        active      = run_i && (cfg_i.factor != '0) && !cfg_changed;
        terminal    = (cnt_q == cfg_i.factor - DIV_W'(1));
        stb_o       = active && tick && terminal;
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_i;
        if (rst || !run_i || cfg_changed) begin
            cnt_q <= '0;
        end else if (active && tick) begin
            cnt_q <= terminal ? '0 : cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/pwmclk_chansel.sv
module pwmclk_chansel
    import pwmclk_pkg::*;
#(
    parameter int NUM_CHAN = 4
) (
    input  src_vec_t                  srcs_i,
    input  logic [NUM_CHAN*SEL_W-1:0] sel_i,
    output logic [NUM_CHAN-1:0]       stb_o
);

    genvar c;
    generate
        for (c = 0; c < NUM_CHAN; c++) begin : g_chan
            assign stb_o[c] = src_pick(srcs_i, sel_i[c*SEL_W +: SEL_W]);
        end
    endgenerate

endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
    import pwmclk_pkg::*;
#(
    parameter int NUM_CHAN = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enable,
    input  logic [SEL_W-1:0]          div_a_presel,
    input  logic [DIV_W-1:0]          div_a_factor,
    input  logic [SEL_W-1:0]          div_b_presel,
    input  logic [DIV_W-1:0]          div_b_factor,
    input  logic [NUM_CHAN*SEL_W-1:0] chan_sel,
    output logic [NUM_TAPS-1:0]       tap_stb,
    output logic                      clka_stb,
    output logic                      clkb_stb,
    output logic [NUM_CHAN-1:0]       chan_stb
);

    logic     run;
    tap_vec_t taps;
    div_cfg_t cfg_a;
    div_cfg_t cfg_b;
    src_vec_t srcs;

    assign run   = enable && !rst;
    assign cfg_a = '{presel: div_a_presel, factor: div_a_factor};
    assign cfg_b = '{presel: div_b_presel, factor: div_b_factor};

    pwmclk_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .taps_o (taps)
    );

    pwmclk_lindiv u_div_a (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .taps_i (taps),
        .cfg_i  (cfg_a),
        .stb_o  (clka_stb)
    );

    pwmclk_lindiv u_div_b (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .taps_i (taps),
        .cfg_i  (cfg_b),
        .stb_o  (clkb_stb)
    );

    assign srcs = {clkb_stb, clka_stb, taps};

    pwmclk_chansel #(.NUM_CHAN(NUM_CHAN)) u_sel (
        .srcs_i (srcs),
        .sel_i  (chan_sel),
        .stb_o  (chan_stb)
    );

    assign tap_stb = taps;

endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk
    import pwmclk_pkg::*;
#(
    parameter int NUM_CHAN = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      enable,
    input logic [SEL_W-1:0]          div_a_presel,
    input logic [DIV_W-1:0]          div_a_factor,
    input logic [SEL_W-1:0]          div_b_presel,
    input logic [DIV_W-1:0]          div_b_factor,
    input logic [NUM_CHAN*SEL_W-1:0] chan_sel,
    input logic [NUM_TAPS-1:0]       tap_stb,
    input logic                      clka_stb,
    input logic                      clkb_stb,
    input logic [NUM_CHAN-1:0]       chan_stb
);

    // R6
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (tap_stb == '0 && !clka_stb && !clkb_stb && chan_stb == '0));

    // R1
    tap_nesting_chk: assert property (@(posedge clk) disable iff (rst)
        (tap_stb[NUM_TAPS-1:1] & ~tap_stb[NUM_TAPS-2:0]) == '0);

    // R2
    a_on_tap_chk: assert property (@(posedge clk) disable iff (rst)
        clka_stb |-> |(tap_stb & (NUM_TAPS'(1) << div_a_presel)));

    // R2
    b_on_tap_chk: assert property (@(posedge clk) disable iff (rst)
        clkb_stb |-> |(tap_stb & (NUM_TAPS'(1) << div_b_presel)));

    // R4
    a_zero_off_chk: assert property (@(posedge clk) disable iff (rst)
        (div_a_factor == '0) |-> !clka_stb);

    // R4
    b_zero_off_chk: assert property (@(posedge clk) disable iff (rst)
        (div_b_factor == '0) |-> !clkb_stb);

    // R5
    a_badsel_off_chk: assert property (@(posedge clk) disable iff (rst)
        (div_a_presel >= SEL_W'(NUM_TAPS)) |-> !clka_stb);

    // R5
    b_badsel_off_chk: assert property (@(posedge clk) disable iff (rst)
        (div_b_presel >= SEL_W'(NUM_TAPS)) |-> !clkb_stb);

    // R8
    a_change_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (div_a_presel != $past(div_a_presel) || div_a_factor != $past(div_a_factor)) |-> !clka_stb);

    // R8
    b_change_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (div_b_presel != $past(div_b_presel) || div_b_factor != $past(div_b_factor)) |-> !clkb_stb);

    genvar c;
    generate
        for (c = 0; c < NUM_CHAN; c++) begin : g_chk
            // R9
            chan_a_route_chk: assert property (@(posedge clk) disable iff (rst)
                (chan_sel[c*SEL_W +: SEL_W] == SEL_W'(SRC_A)) |-> (chan_stb[c] == clka_stb));
            // R9
            chan_b_route_chk: assert property (@(posedge clk) disable iff (rst)
                (chan_sel[c*SEL_W +: SEL_W] == SEL_W'(SRC_B)) |-> (chan_stb[c] == clkb_stb));
            // R10
            chan_dead_chk: assert property (@(posedge clk) disable iff (rst)
                (chan_sel[c*SEL_W +: SEL_W] > SEL_W'(SRC_B)) |-> !chan_stb[c]);
        end
    endgenerate

endmodule

bind pwm_clkgen pwm_clkgen_chk #(.NUM_CHAN(NUM_CHAN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .div_a_presel (div_a_presel),
    .div_a_factor (div_a_factor),
    .div_b_presel (div_b_presel),
    .div_b_factor (div_b_factor),
    .chan_sel     (chan_sel),
    .tap_stb      (tap_stb),
    .clka_stb     (clka_stb),
    .clkb_stb     (clkb_stb),
    .chan_stb     (chan_stb)
);

// File: tb/tb_pwm_clkgen.sv
`timescale 1ns/1ps
module tb_pwm_clkgen;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [3:0]  div_a_presel = '0;
    logic [7:0]  div_a_factor = '0;
    logic [3:0]  div_b_presel = '0;
    logic [7:0]  div_b_factor = '0;
    logic [15:0] chan_sel = '0;
    logic [10:0] tap_stb;
    logic        clka_stb;
    logic        clkb_stb;
    logic [3:0]  chan_stb;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwm_clkgen #(.NUM_CHAN(NCH)) dut (
        .clk(clk), .rst(rst), .enable(enable),
        .div_a_presel(div_a_presel), .div_a_factor(div_a_factor),
        .div_b_presel(div_b_presel), .div_b_factor(div_b_factor),
        .chan_sel(chan_sel), .tap_stb(tap_stb),
        .clka_stb(clka_stb), .clkb_stb(clkb_stb), .chan_stb(chan_stb)
    );

    typedef struct packed {
        logic [3:0]  psel;
        logic [7:0]  fac;
        logic [31:0] per;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{psel: 4'd0,  fac: 8'd1,   per: 32'd1},
        '{psel: 4'd0,  fac: 8'd255, per: 32'd255},
        '{psel: 4'd1,  fac: 8'd3,   per: 32'd6},
        '{psel: 4'd2,  fac: 8'd255, per: 32'd1020},
        '{psel: 4'd3,  fac: 8'd7,   per: 32'd56},
        '{psel: 4'd5,  fac: 8'd10,  per: 32'd320},
        '{psel: 4'd7,  fac: 8'd2,   per: 32'd256},
        '{psel: 4'd10, fac: 8'd3,   per: 32'd3072}
    };

    function automatic logic sig(input int src);
        if (src < 11)       return tap_stb[src];
        else if (src == 11) return clka_stb;
        else if (src == 12) return clkb_stb;
        else                return chan_stb[src-13];
    endfunction

    function automatic logic any_stb();
        return (|tap_stb) || clka_stb || clkb_stb || (|chan_stb);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Cycles between two consecutive strobes of a source; -1 if none within limit.
    task automatic gap_of(input int src, input int limit, output int gap);
        int n;
        gap = -1;
        n = 0;
        while (!sig(src) && n < limit) begin @(negedge clk); n++; end
        if (!sig(src)) return;
        n = 0;
        do begin @(negedge clk); n++; end while (!sig(src) && n < limit);
        if (sig(src)) gap = n;
    endtask

    // Number of strobes of a source over a window.
    task automatic count_of(input int src, input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sig(src)) cnt++;
        end
    endtask

    initial begin
        int g;
        int gb;
        int n;
        int quiet;

        // Reset state (R6): strobes low while in reset, even with enable high.
        enable = 1'b1;
        quiet = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (any_stb()) quiet++;
        end
        check("R6 reset quiet", quiet, 0);
        rst = 1'b0;

        // R1: each tap period.
        for (int k = 0; k < 11; k++) begin
            @(negedge clk);
            gap_of(k, 4000, g);
            check($sformatf("R1 tap %0d period", k), g, 1 << k);
        end

        // R2 / R3: vector table, A and B configured differently at once.
        for (int i = 0; i < NV; i++) begin
            int j;
            j = (i + 3) % NV;
            @(negedge clk);
            div_a_presel = VECS[i].psel; div_a_factor = VECS[i].fac;
            div_b_presel = VECS[j].psel; div_b_factor = VECS[j].fac;
            @(negedge clk);
            gap_of(11, 8000, g);
            check($sformatf("R2 A p=%0d f=%0d", VECS[i].psel, VECS[i].fac), g, int'(VECS[i].per));
            gap_of(12, 8000, gb);
            check($sformatf("R3 B p=%0d f=%0d", VECS[j].psel, VECS[j].fac), gb, int'(VECS[j].per));
        end

        // R4: factor 0 turns divider off.
        @(negedge clk);
        div_a_presel = 4'd0; div_a_factor = 8'd0;
        div_b_presel = 4'd0; div_b_factor = 8'd0;
        count_of(11, 300, n);
        check("R4 A factor 0 off", n, 0);
        count_of(12, 50, n);
        check("R4 B factor 0 off", n, 0);

        // R5: select codes 11..15 turn divider off.
        for (int s = 11; s < 16; s++) begin
            @(negedge clk);
            div_a_presel = 4'(s); div_a_factor = 8'd1;
            div_b_presel = 4'(s); div_b_factor = 8'd2;
            count_of(11, 60, n);
            check($sformatf("R5 A sel %0d off", s), n, 0);
            count_of(12, 10, n);
            check($sformatf("R5 B sel %0d off", s), n, 0);
        end

        // R8: change restarts the count; next strobe exactly f cycles later.
        @(negedge clk);
        div_a_presel = 4'd0; div_a_factor = 8'd200;
        repeat (50) @(negedge clk);
        div_a_factor = 8'd5;
        n = 0;
        do begin @(negedge clk); n++; end while (!clka_stb && n < 400);
        check("R8 restart after write", n, 5);

        // R8: write lands in the cycle a strobe is due; the write wins.
        @(negedge clk);
        div_a_factor = 8'd4;
        @(negedge clk);
        while (!clka_stb) @(negedge clk);
        repeat (3) @(negedge clk);
        @(posedge clk); #1;
        div_a_factor = 8'd3;
        @(negedge clk);
        check("R8 collision strobe suppressed", int'(clka_stb), 0);
        n = 0;
        do begin @(negedge clk); n++; end while (!clka_stb && n < 400);
        check("R8 collision new period", n, 3);

        // R9 / R10: channel routing.
        @(negedge clk);
        div_a_presel = 4'd1; div_a_factor = 8'd3;
        div_b_presel = 4'd0; div_b_factor = 8'd9;
        chan_sel = {4'd13, 4'd4, 4'd12, 4'd11};
        @(negedge clk);
        gap_of(13, 2000, g);
        check("R9 ch0 code 11 -> A", g, 6);
        gap_of(14, 2000, g);
        check("R9 ch1 code 12 -> B", g, 9);
        gap_of(15, 2000, g);
        check("R9 ch2 code 4 -> tap4", g, 16);
        count_of(16, 200, n);
        check("R10 ch3 code 13 dead", n, 0);
        @(negedge clk);
        chan_sel = {4'd15, 4'd14, 4'd10, 4'd0};
        gap_of(13, 2000, g);
        check("R9 ch0 code 0 -> tap0", g, 1);
        gap_of(15, 2000, g);
        check("R10 ch2 code 14 dead", g, -1);
        gap_of(14, 3000, g);
        check("R9 ch1 code 10 -> tap10", g, 1024);

        // R6: enable low keeps everything quiet.
        @(negedge clk);
        chan_sel = {4'd11, 4'd12, 4'd3, 4'd0};
        enable = 1'b0;
        quiet = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (any_stb()) quiet++;
        end
        check("R6 enable low quiet", quiet, 0);

        // R7: counter restarts when enable rises.
        enable = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!tap_stb[3] && n < 100);
        check("R7 tap3 first after enable", n, 7);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc >= 190000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule